// File: doc/BRIEF.md
# Two-level LPC interrupt aggregator

This block collects interrupt sources of an LPC host controller and reduces them to one level-sensitive interrupt line. The first stage is the host-controller stage: seventeen serial-IRQ lines and a set of bus event inputs are latched into a status register. Only software clears that register, by writing ones. The OR of status AND mask, gated by an enable bit in a control register, forms the host-controller summary.

The summary drives bit 11 of the input register of a second stage, the bus-master stage. On every clock cycle that stage folds its masked input into a sticky status register. Its output interrupt is high while any status bit is set. The master stage also keeps two route registers and a polarity register as plain storage.

Both register files share one 32-bit register bus. Address bit 8 selects the bank: 1 selects the host-controller bank and 0 selects the master bank. Reads return data one clock after the read strobe.

Top module: `lpc_irq_aggregator`

## Requirements
- R1: After reset, every control, mask, status, route and polarity register reads as zero and `irq_out` is low.
- R2: While serial-IRQ line n (0 to 16) is high at a clock edge, host-controller status bit (31 − n) becomes 1. It stays 1 after the line goes low.
- R3: Event input bits 10 and 7..0 set the host-controller status bits at the same positions. Event bits 9 and 8 are reserved and never set status. Status bits 14..11 and 9..8 always read zero.
- R4: Writing host-controller status (0x138) clears each bit written as 1. A bit whose source is high in the same cycle stays set.
- R5: The host-controller summary is the OR over (status AND mask, 0x134), and it is forced low while control (0x130) bit 31 is 0. The summary is visible as bit 11 (value 0x800) of the master input register (0x05C), in the same cycle as the host-controller registers that produce it.
- R6: The master input register is read-only. Writes to 0x05C have no effect.
- R7: On every cycle, master status (0x050) is updated as status |= input AND mask (0x054). Writing 1s to master status clears those bits. A cleared bit whose masked input is still active sets again on the next cycle.
- R8: `irq_out` is high exactly when master status is nonzero.
- R9: The route registers (0x008, 0x00C) and the polarity register (0x058) read back the last value written. Polarity has no effect on any interrupt.
- R10: A read of any other address, including an unaligned one, returns 0xFFFFFFFF.
- R11: `bus_rdata` loads on the clock edge that samples `bus_rd` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 9 | Byte address; bit 8 selects the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| serirq_lvl | input | 17 | Serial-IRQ line levels, bit n is IRQ n |
| evt_in | input | 11 | Bus event and request sources, aligned to status bits 10..0 |
| irq_out | output | 1 | Aggregated level interrupt |

## Verification
The bench goes after the cases that separate the two stages.

- **Clearing the host-controller status while a serial line is still high.** The bit must survive. A design that lets the clear win would lose the interrupt.
- **Clearing the master status while the host-controller summary is still active.** The bit must return one cycle later. A non-sticky or edge-based master would drop `irq_out`.
- **Clearing the host-controller status while the master status is set.** The master status must stay set.
- **Enable gating.** With control bit 31 clear, a fully masked-in status must not reach the master input.
- **Ignored writes and unmapped addresses.** Writes to the input register must change nothing, and unaligned or unmapped reads must return all ones.

// File: rtl/lpc_irq_pkg.sv
// Shared constants for the two-level LPC interrupt aggregator.
// Assumes byte offsets inside one bank fit in 8 bits.
package lpc_irq_pkg;
    localparam logic [7:0] HC_CTRL_OFS    = 8'h30;
    localparam logic [7:0] HC_MASK_OFS    = 8'h34;
    localparam logic [7:0] HC_STAT_OFS    = 8'h38;
    localparam logic [7:0] MS_ROUTE0_OFS  = 8'h08;
    localparam logic [7:0] MS_ROUTE1_OFS  = 8'h0C;
    localparam logic [7:0] MS_STAT_OFS    = 8'h50;
    localparam logic [7:0] MS_MASK_OFS    = 8'h54;
    localparam logic [7:0] MS_POL_OFS     = 8'h58;
    localparam logic [7:0] MS_INPUT_OFS   = 8'h5C;
    localparam int         HC_EN_BIT      = 31;
    localparam int         MS_HC_BIT      = 11;
    localparam logic [10:0] EVT_IMPL_MASK = 11'h4FF;

    typedef enum logic [1:0] {
        BANK_MASTER = 2'd0,
        BANK_HC     = 2'd1
    } bank_e;
endpackage

// File: rtl/lpc_hc_irq_stage.sv
// Host-controller interrupt stage.
// Latches serial-IRQ levels and event inputs into a status register that
// only software clears (write 1 to clear). Holds the control and mask
// registers, and produces the gated, masked summary for the master stage.
// Assumes N_SERIRQ + EVT_W <= DATA_W. Serial line n maps to bit DATA_W-1-n.
module lpc_hc_irq_stage #(
    parameter int               DATA_W   = 32,
    parameter int               N_SERIRQ = 17,
    parameter int               EVT_W    = 11,
    parameter logic [EVT_W-1:0] EVT_IMPL = 11'h4FF,
    parameter int               EN_BIT   = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SERIRQ-1:0] serirq_i,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic              ctrl_we,
    input  logic              mask_we,
    input  logic              stat_w1c,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] stat_o,
    output logic              hc_irq_o
);
    localparam int SER_LO = DATA_W - N_SERIRQ;

    logic [DATA_W-1:0] ctrl_q, mask_q, stat_q;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;

    // Serial lines fill the status word from the top bit downward.
    for (genvar n = 0; n < N_SERIRQ; n++) begin : g_ser
        assign set_vec[DATA_W-1-n] = serirq_i[n];
    end

    // Event sources sit at the low bits; the reserved ones are filtered out.
    for (genvar b = 0; b < SER_LO; b++) begin : g_evt
        if (b < EVT_W) begin : g_live
            assign set_vec[b] = evt_i[b] & EVT_IMPL[b];
        end else begin : g_gap
            assign set_vec[b] = 1'b0;
        end
    end

    // Clear vector from a status write.
    assign clr_vec = stat_w1c ? wdata : '0;

    // Register file update: control, mask, and level-latched status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
            stat_q <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= wdata;
            if (mask_we) mask_q <= wdata;
            stat_q <= (stat_q & ~clr_vec) | set_vec;
        end
    end

    // Summary toward the master stage.
    always_comb begin
        hc_irq_o = ctrl_q[EN_BIT] & (|(stat_q & mask_q));
    end

    assign ctrl_o = ctrl_q;
    assign mask_o = mask_q;
    assign stat_o = stat_q;

    // R2: a set status bit is lost only through a write-1-to-clear.
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(stat_q) & ~$past(clr_vec) & ~stat_q) == '0));

    // R4: a bit written as 1 is zero afterwards unless its source was high.
    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_w1c |=> ((stat_q & $past(wdata) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/lpc_master_irq_stage.sv
// Bus-master interrupt stage.
// Folds its masked input into a sticky status register on every cycle,
// clears status bits written as 1, and raises a level interrupt while
// any status bit is set. Route and polarity registers are storage only.
// Assumes the host-controller summary is the only live input bit.
module lpc_master_irq_stage #(
    parameter int DATA_W = 32,
    parameter int HC_BIT = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hc_irq_i,
    input  logic              route0_we,
    input  logic              route1_we,
    input  logic              mask_we,
    input  logic              pol_we,
    input  logic              stat_w1c,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] route0_o,
    output logic [DATA_W-1:0] route1_o,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] pol_o,
    output logic [DATA_W-1:0] stat_o,
    output logic [DATA_W-1:0] input_o,
    output logic              irq_o
);
    logic [DATA_W-1:0] route0_q, route1_q, mask_q, pol_q, stat_q;
    logic [DATA_W-1:0] in_vec;
    logic [DATA_W-1:0] clr_vec;

    // Input word: the host-controller summary at its fixed bit.
    for (genvar b = 0; b < DATA_W; b++) begin : g_in
        if (b == HC_BIT) begin : g_hc
            assign in_vec[b] = hc_irq_i;
        end else begin : g_zero
            assign in_vec[b] = 1'b0;
        end
    end

    assign clr_vec = stat_w1c ? wdata : '0;

    // Storage registers and the sticky status latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route0_q <= '0;
            route1_q <= '0;
            mask_q   <= '0;
            pol_q    <= '0;
            stat_q   <= '0;
        end else begin
            if (route0_we) route0_q <= wdata;
            if (route1_we) route1_q <= wdata;
            if (mask_we)   mask_q   <= wdata;
            if (pol_we)    pol_q    <= wdata;
            stat_q <= (stat_q & ~clr_vec) | (in_vec & mask_q);
        end
    end

    // Level output.
    always_comb begin
        irq_o = |stat_q;
    end

    assign route0_o = route0_q;
    assign route1_o = route1_q;
    assign mask_o   = mask_q;
    assign pol_o    = pol_q;
    assign stat_o   = stat_q;
    assign input_o  = in_vec;

    // R7: a status bit can only appear if its masked input was active.
    p_set_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(in_vec & mask_q)) == '0));

    // R7: a masked, active input is always present in status next cycle.
    p_fold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(in_vec & mask_q) & ~stat_q) == '0));

    // R8: the interrupt rises only after a masked input was seen.
    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|(in_vec & mask_q)));
endmodule

// File: rtl/lpc_irq_aggregator.sv
// Top of the two-level LPC interrupt aggregator.
// Decodes the shared 32-bit register bus into the two stages, chains the
// host-controller summary into the master input, and registers read data.
// Assumes the top address bit picks the bank and the rest is the offset.
module lpc_irq_aggregator #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 9,
    parameter int N_SERIRQ = 17,
    parameter int EVT_W    = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [N_SERIRQ-1:0] serirq_lvl,
    input  logic [EVT_W-1:0]    evt_in,
    output logic                irq_out
);
    import lpc_irq_pkg::*;

    localparam int OFF_W = ADDR_W - 1;

    bank_e             bank;
    logic [OFF_W-1:0]  off;
    logic              hc_wr, ms_wr;
    logic [DATA_W-1:0] hc_ctrl, hc_mask, hc_stat;
    logic [DATA_W-1:0] ms_r0, ms_r1, ms_mask, ms_pol, ms_stat, ms_in;
    logic              hc_irq;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    // Address split into bank and offset.
    always_comb begin
        bank = bus_addr[ADDR_W-1] ? BANK_HC : BANK_MASTER;
        off  = bus_addr[OFF_W-1:0];
    end

    assign hc_wr = bus_wr && (bank == BANK_HC);
    assign ms_wr = bus_wr && (bank == BANK_MASTER);

    lpc_hc_irq_stage #(
        .DATA_W  (DATA_W),
        .N_SERIRQ(N_SERIRQ),
        .EVT_W   (EVT_W),
        .EVT_IMPL(EVT_W'(EVT_IMPL_MASK)),
        .EN_BIT  (HC_EN_BIT)
    ) u_hc (
        .clk     (clk),
        .rst_n   (rst_n),
        .serirq_i(serirq_lvl),
        .evt_i   (evt_in),
        .ctrl_we (hc_wr && off == OFF_W'(HC_CTRL_OFS)),
        .mask_we (hc_wr && off == OFF_W'(HC_MASK_OFS)),
        .stat_w1c(hc_wr && off == OFF_W'(HC_STAT_OFS)),
        .wdata   (bus_wdata),
        .ctrl_o  (hc_ctrl),
        .mask_o  (hc_mask),
        .stat_o  (hc_stat),
        .hc_irq_o(hc_irq)
    );

    lpc_master_irq_stage #(
        .DATA_W(DATA_W),
        .HC_BIT(MS_HC_BIT)
    ) u_ms (
        .clk      (clk),
        .rst_n    (rst_n),
        .hc_irq_i (hc_irq),
        .route0_we(ms_wr && off == OFF_W'(MS_ROUTE0_OFS)),
        .route1_we(ms_wr && off == OFF_W'(MS_ROUTE1_OFS)),
        .mask_we  (ms_wr && off == OFF_W'(MS_MASK_OFS)),
        .pol_we   (ms_wr && off == OFF_W'(MS_POL_OFS)),
        .stat_w1c (ms_wr && off == OFF_W'(MS_STAT_OFS)),
        .wdata    (bus_wdata),
        .route0_o (ms_r0),
        .route1_o (ms_r1),
        .mask_o   (ms_mask),
        .pol_o    (ms_pol),
        .stat_o   (ms_stat),
        .input_o  (ms_in),
        .irq_o    (irq_out)
    );

    // Read selection; unmapped offsets return all ones.
    always_comb begin
        rd_mux = '1;
        if (bank == BANK_HC) begin
            if (off == OFF_W'(HC_CTRL_OFS))      rd_mux = hc_ctrl;
            else if (off == OFF_W'(HC_MASK_OFS)) rd_mux = hc_mask;
            else if (off == OFF_W'(HC_STAT_OFS)) rd_mux = hc_stat;
        end else begin
            if (off == OFF_W'(MS_ROUTE0_OFS))      rd_mux = ms_r0;
            else if (off == OFF_W'(MS_ROUTE1_OFS)) rd_mux = ms_r1;
            else if (off == OFF_W'(MS_STAT_OFS))   rd_mux = ms_stat;
            else if (off == OFF_W'(MS_MASK_OFS))   rd_mux = ms_mask;
            else if (off == OFF_W'(MS_POL_OFS))    rd_mux = ms_pol;
            else if (off == OFF_W'(MS_INPUT_OFS))  rd_mux = ms_in;
        end
    end

    // Read data register, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    // R11: read data holds when no read was sampled.
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R5: with the enable bit clear, the master input bit never appears.
    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !hc_ctrl[HC_EN_BIT] |-> (ms_in == '0));
endmodule

// File: tb/lpc_irq_aggregator_tb_top.sv
// Bench for the two-level LPC interrupt aggregator. A behavioural model
// advances on each rising edge. Its interrupt is compared on every falling
// edge, and its read data is compared after each read.
module lpc_irq_aggregator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [16:0] serirq_lvl = '0;
    logic [10:0] evt_in = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Model state.
    logic [31:0] m_ctrl, m_hmask, m_hst, m_r0, m_r1, m_mmask, m_pol, m_mst;
    logic [31:0] m_exp_rd;

    always #2 clk = ~clk;

    lpc_irq_aggregator dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .serirq_lvl(serirq_lvl), .evt_in(evt_in), .irq_out(irq_out)
    );

    function automatic logic [31:0] m_input();
        return (m_ctrl[31] && ((m_hst & m_hmask) != 0)) ? 32'h800 : 32'h0;
    endfunction

    function automatic logic [31:0] m_read(input logic [8:0] a);
        case (a)
            9'h130: return m_ctrl;
            9'h134: return m_hmask;
            9'h138: return m_hst;
            9'h008: return m_r0;
            9'h00C: return m_r1;
            9'h050: return m_mst;
            9'h054: return m_mmask;
            9'h058: return m_pol;
            9'h05C: return m_input();
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Behavioural model step, on the same edge the design uses.
    always @(posedge clk) begin
        logic [31:0] setv, nmst;
        if (!rst_n) begin
            m_ctrl = 0; m_hmask = 0; m_hst = 0; m_r0 = 0;
            m_r1 = 0; m_mmask = 0; m_pol = 0; m_mst = 0;
        end else begin
            if (bus_rd) m_exp_rd = m_read(bus_addr);
            nmst = m_mst | (m_input() & m_mmask);
            if (bus_wr && bus_addr == 9'h050) nmst = (m_mst & ~bus_wdata) | (m_input() & m_mmask);
            setv = 0;
            for (int n = 0; n < 17; n++) if (serirq_lvl[n]) setv[31-n] = 1'b1;
            for (int b = 0; b < 11; b++) if (evt_in[b] && b != 8 && b != 9) setv[b] = 1'b1;
            if (bus_wr && bus_addr == 9'h138) m_hst = (m_hst & ~bus_wdata) | setv;
            else m_hst = m_hst | setv;
            m_mst = nmst;
            if (bus_wr) begin
                case (bus_addr)
                    9'h130: m_ctrl = bus_wdata;
                    9'h134: m_hmask = bus_wdata;
                    9'h008: m_r0 = bus_wdata;
                    9'h00C: m_r1 = bus_wdata;
                    9'h054: m_mmask = bus_wdata;
                    9'h058: m_pol = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R8: the interrupt is compared with the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n) check("R8 irq per cycle", {31'b0, irq_out}, {31'b0, (m_mst != 0)});
    end

    // Watchdog: an expired timer counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check(tag, bus_rdata, exp);
        check({tag, " model"}, bus_rdata, m_exp_rd);
    endtask

    task automatic ser_pulse(input int n);
        @(negedge clk);
        serirq_lvl[n] = 1'b1;
        @(negedge clk);
        serirq_lvl[n] = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq after reset", {31'b0, irq_out}, 32'h0);
        rd(9'h130, 32'h0, "R1 ctrl");
        rd(9'h134, 32'h0, "R1 hc mask");
        rd(9'h138, 32'h0, "R1 hc status");
        rd(9'h008, 32'h0, "R1 route0");
        rd(9'h00C, 32'h0, "R1 route1");
        rd(9'h050, 32'h0, "R1 master status");
        rd(9'h054, 32'h0, "R1 master mask");
        rd(9'h058, 32'h0, "R1 polarity");
        rd(9'h05C, 32'h0, "R1 master input");
        // R10 unmapped and unaligned
        rd(9'h000, 32'hFFFF_FFFF, "R10 master 0x00");
        rd(9'h010, 32'hFFFF_FFFF, "R10 master 0x10");
        rd(9'h13C, 32'hFFFF_FFFF, "R10 hc 0x3C");
        rd(9'h132, 32'hFFFF_FFFF, "R10 unaligned");
        rd(9'h030, 32'hFFFF_FFFF, "R10 hc offset in master bank");
        // R9 storage
        wr(9'h008, 32'hA5A5_0001);
        wr(9'h00C, 32'h1234_5678);
        wr(9'h058, 32'hFFFF_FFFF);
        rd(9'h008, 32'hA5A5_0001, "R9 route0");
        rd(9'h00C, 32'h1234_5678, "R9 route1");
        rd(9'h058, 32'hFFFF_FFFF, "R9 polarity");
        // R11 hold after idle cycles
        idle(3);
        check("R11 rdata holds", bus_rdata, 32'hFFFF_FFFF);
        // R2 serial lines
        ser_pulse(0);
        idle(2);
        rd(9'h138, 32'h8000_0000, "R2 irq0 to bit31");
        ser_pulse(16);
        ser_pulse(5);
        rd(9'h138, 32'h8400_8000, "R2 irq16 and irq5");
        // R3 events
        @(negedge clk); evt_in = 11'h7FF;
        @(negedge clk); evt_in = 11'h000;
        rd(9'h138, 32'h8400_84FF, "R3 events, reserved excluded");
        // R5 gating
        wr(9'h134, 32'hFFFF_FFFF);
        rd(9'h05C, 32'h0, "R5 gated by enable");
        check("R9 polarity no effect on irq", {31'b0, irq_out}, 32'h0);
        wr(9'h130, 32'h8000_0000);
        rd(9'h05C, 32'h800, "R5 input bit 11");
        rd(9'h050, 32'h0, "R7 unmasked input not latched");
        // R6 input read-only
        wr(9'h05C, 32'hFFFF_FFFF);
        rd(9'h05C, 32'h800, "R6 input ignores write");
        rd(9'h050, 32'h0, "R6 status untouched");
        // R7/R8 master latch
        wr(9'h054, 32'h800);
        idle(1);
        check("R8 irq high", {31'b0, irq_out}, 32'h1);
        rd(9'h050, 32'h800, "R7 master status set");
        wr(9'h050, 32'h800);
        rd(9'h050, 32'h800, "R7 re-set while active");
        // R4 clear host status, master stays
        wr(9'h138, 32'hFFFF_FFFF);
        rd(9'h138, 32'h0, "R4 hc status cleared");
        rd(9'h05C, 32'h0, "R5 input drops");
        rd(9'h050, 32'h800, "R7 master sticky");
        check("R8 irq still high", {31'b0, irq_out}, 32'h1);
        wr(9'h050, 32'h800);
        rd(9'h050, 32'h0, "R7 master cleared");
        check("R8 irq low", {31'b0, irq_out}, 32'h0);
        // R4 clear while line held high
        @(negedge clk); serirq_lvl[3] = 1'b1;
        wr(9'h138, 32'h1000_0000);
        rd(9'h138, 32'h1000_0000, "R4 set wins over clear");
        @(negedge clk); serirq_lvl[3] = 1'b0;
        wr(9'h138, 32'h1000_0000);
        rd(9'h138, 32'h0, "R4 cleared after release");
        // R5 disable stops a pending source
        wr(9'h050, 32'hFFFF_FFFF);
        wr(9'h130, 32'h0);
        ser_pulse(1);
        wr(9'h050, 32'hFFFF_FFFF);
        idle(3);
        rd(9'h138, 32'h4000_0000, "R2 irq1 latched while disabled");
        rd(9'h05C, 32'h0, "R5 disabled input");
        rd(9'h050, 32'h0, "R5 no master set when disabled");
        check("R8 irq low when disabled", {31'b0, irq_out}, 32'h0);
        rd(9'h008, 32'hA5A5_0001, "R9 route0 retained");
        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule